// File: doc/BRIEF.md
# Transmit Interrupt Coalescing Timer

This block holds back transmit-completion interrupts so that a single interrupt can reclaim a batch of transmitted buffers. Each descriptor write-back event carries two flags: report-status and delay-enable. When both are set, the event starts a countdown, or starts it again from the top. The countdown runs for a programmed number of time-base ticks. When the count expires, the block emits a one-cycle interrupt-cause pulse. An event that asks for status but not for delay is reported at once and drops any countdown in progress.

Software sets the delay in a 32-bit control word. The low 16 bits hold the delay in time-base units. The top bit is a strobe that only takes effect on a write: it flushes a pending countdown so that it reports straight away. The bits in between are ignored on write and read as zero. A programmed delay of zero is not a valid setting, and the block treats it as one unit so that the timer can never hang.

Top module: `txic_coalesce_timer`

## Requirements
- R1: A control write stores bits 15:0 as the delay. A read returns the delay in bits 15:0 and zero in bits 31:16, including the flush bit 31 and whatever was written to bits 30:16.
- R2: An event with valid, report-status and delay-enable all high loads a countdown of N = delay. On each tick the count drops by one. irq_o is high for exactly one cycle, in the cycle after the Nth tick.
- R3: A programmed delay of zero behaves as a delay of one tick.
- R4: A second qualifying event during a countdown restarts it at the full delay. The pulse then comes N ticks after the second event.
- R5: An event with report-status high and delay-enable low sets irq_o in the next cycle and ends any running countdown, so that no later pulse comes from it.
- R6: An event with report-status low never produces a pulse and starts no countdown.
- R7: A control write with bit 31 set while a countdown runs sets irq_o in the next cycle and ends the countdown.
- R8: A control write with bit 31 set while no countdown runs produces no pulse, then or later.
- R9: After reset, irq_o is low, the delay reads as zero and no countdown runs.
- R10: Ticks that arrive while no countdown runs produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 32 | Control word write data (bit 31 flush, bits 15:0 delay) |
| cfg_rdata_o | output | 32 | Control word read data |
| tick_i | input | 1 | Time-base tick, one cycle wide |
| wb_valid_i | input | 1 | Descriptor write-back event strobe |
| wb_rs_i | input | 1 | Event requests status reporting |
| wb_ide_i | input | 1 | Event requests delayed reporting |
| irq_o | output | 1 | Interrupt-cause pulse |

## Verification
The assertions assume that an event arrives for at most one cycle at a time, with its flags valid alongside it. They also assume that a tick is a single-cycle strobe. When several causes coincide in one cycle, the resolution order is fixed: an immediate report comes first, then a flush, then a reload, then expiry. The stimulus drives every input only at the falling edge and raises each strobe for one cycle. Events, ticks and control writes go in separate cycles, except where the stimulus deliberately checks a restart in the middle of a countdown.

// File: rtl/txic_pkg.sv
package txic_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned DLY_W     = 16;
  localparam int unsigned FLUSH_BIT = 31;

  typedef struct packed {
    logic qual;  // report + delay requested
    logic imm;   // report only
  } wb_evt_t;
endpackage

// File: rtl/txic_cfg_reg.sv
module txic_cfg_reg #(
  parameter int unsigned REG_W     = 32,
  parameter int unsigned DLY_W     = 16,
  parameter int unsigned FLUSH_BIT = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [DLY_W-1:0] eff_dly_o,
  output logic             flush_o
);
  localparam int unsigned PAD_W = REG_W - DLY_W;

  logic [DLY_W-1:0] dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dly_q <= '0;
    else if (we_i) dly_q <= wdata_i[DLY_W-1:0];
  end

  // zero is illegal; clamp to one unit
  assign eff_dly_o = (dly_q == '0) ? DLY_W'(1) : dly_q;
  assign flush_o   = we_i & wdata_i[FLUSH_BIT];
  assign rdata_o   = {{PAD_W{1'b0}}, dly_q};

  a_r1_delay_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o[DLY_W-1:0] == $past(wdata_i[DLY_W-1:0]));
endmodule

// File: rtl/txic_event_qual.sv
module txic_event_qual
  import txic_pkg::*;
(
  input  logic    valid_i,
  input  logic    rs_i,
  input  logic    ide_i,
  output wb_evt_t evt_o
);
  always_comb begin
    evt_o.qual = valid_i & rs_i & ide_i;
    evt_o.imm  = valid_i & rs_i & ~ide_i;
  end
endmodule

// File: rtl/txic_countdown.sv
module txic_countdown #(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DLY_W-1:0] load_val_i,
  input  logic             cancel_i,
  input  logic             flush_i,
  input  logic             tick_i,
  output logic             irq_o
);
  logic [DLY_W-1:0] cnt_q;
  logic             act_q, irq_q;
  logic             expire, flush_hit, irq_d;

  assign expire    = act_q & tick_i & (cnt_q == DLY_W'(1));
  assign flush_hit = flush_i & act_q;

  // reload beats expiry; flush reports what is pending
  always_comb irq_d = cancel_i | flush_hit | (expire & ~load_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      if (load_i) begin
        cnt_q <= load_val_i;
        act_q <= 1'b1;
      end else if (cancel_i | flush_hit | expire) begin
        cnt_q <= '0;
        act_q <= 1'b0;
      end else if (act_q & tick_i) begin
        cnt_q <= cnt_q - DLY_W'(1);
      end
    end
  end

  assign irq_o = irq_q;

  a_r3_active_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> cnt_q != '0);
  a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> act_q && cnt_q == $past(load_val_i));
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && tick_i && !load_i && !cancel_i && !flush_i && cnt_q > DLY_W'(1))
    |=> cnt_q == $past(cnt_q) - DLY_W'(1));
  a_r5_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> irq_o && !act_q);
  a_r7_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && act_q && !load_i) |=> irq_o && !act_q);
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_q && !load_i && !cancel_i) |=> !irq_o);
endmodule

// File: rtl/txic_coalesce_timer.sv
module txic_coalesce_timer
  import txic_pkg::*;
#(
  parameter int unsigned REG_W_P     = REG_W,
  parameter int unsigned DLY_W_P     = DLY_W,
  parameter int unsigned FLUSH_BIT_P = FLUSH_BIT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [REG_W_P-1:0] cfg_wdata_i,
  output logic [REG_W_P-1:0] cfg_rdata_o,
  input  logic               tick_i,
  input  logic               wb_valid_i,
  input  logic               wb_rs_i,
  input  logic               wb_ide_i,
  output logic               irq_o
);
  logic [DLY_W_P-1:0] eff_dly;
  logic               flush;
  wb_evt_t            evt;

  txic_cfg_reg #(
    .REG_W(REG_W_P), .DLY_W(DLY_W_P), .FLUSH_BIT(FLUSH_BIT_P)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .rdata_o  (cfg_rdata_o),
    .eff_dly_o(eff_dly),
    .flush_o  (flush)
  );

  txic_event_qual u_qual (
    .valid_i(wb_valid_i),
    .rs_i   (wb_rs_i),
    .ide_i  (wb_ide_i),
    .evt_o  (evt)
  );

  txic_countdown #(.DLY_W(DLY_W_P)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (evt.qual),
    .load_val_i(eff_dly),
    .cancel_i  (evt.imm),
    .flush_i   (flush),
    .tick_i    (tick_i),
    .irq_o     (irq_o)
  );

  a_r6_no_report_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(wb_valid_i && wb_rs_i) || $past(tick_i) || $past(cfg_we_i));
endmodule

// File: tb/txic_coalesce_timer_tb_top.sv
module txic_coalesce_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        tick = 1'b0, wb_valid = 1'b0, wb_rs = 1'b0, wb_ide = 1'b0;
  logic        irq;

  int checks = 0, failures = 0;
  localparam int NONE = 99;

  always #5 clk = ~clk;

  txic_coalesce_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .tick_i(tick), .wb_valid_i(wb_valid),
    .wb_rs_i(wb_rs), .wb_ide_i(wb_ide), .irq_o(irq)
  );

  // {delay[15:0], rs, ide, expected tick of pulse[7:0]}; 0 = immediate, 99 = never
  localparam logic [25:0] VEC [6] = '{
    {16'd3, 1'b1, 1'b1, 8'd3},
    {16'd1, 1'b1, 1'b1, 8'd1},
    {16'd0, 1'b1, 1'b1, 8'd1},
    {16'd5, 1'b1, 1'b0, 8'd0},
    {16'd4, 1'b0, 1'b1, 8'd99},
    {16'd7, 1'b1, 1'b1, 8'd7}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [31:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic event_in(input logic rs, input logic ide);
    wb_valid = 1'b1; wb_rs = rs; wb_ide = ide;
    @(posedge clk); @(negedge clk);
    wb_valid = 1'b0; wb_rs = 1'b0; wb_ide = 1'b0;
  endtask

  // apply n ticks; return index of the first tick after which irq was seen
  task automatic run_ticks(input int n, output int first);
    first = NONE;
    for (int t = 1; t <= n; t++) begin
      tick = 1'b1;
      @(posedge clk); @(negedge clk);
      tick = 1'b0;
      if (irq && first == NONE) first = t;
    end
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int f;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(irq == 1'b0, "R9 irq", irq, 0);
    chk(cfg_rdata == 32'd0, "R9 rdata", cfg_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 idle ticks
    run_ticks(5, f);
    chk(f == NONE, "R10 idle ticks", f, NONE);
    // R1 readback with reserved and flush bits set
    cfg_write(32'hFFFF_1234);
    chk(cfg_rdata == 32'h0000_1234, "R1 readback", cfg_rdata, 32'h0000_1234);

    // vector table: R2 R3 R5 R6
    for (int i = 0; i < 6; i++) begin
      automatic int exp = int'(VEC[i][7:0]);
      cfg_write({16'd0, VEC[i][25:10]});
      event_in(VEC[i][9], VEC[i][8]);
      chk(irq == (exp == 0), "R2/R5 immediate", irq, exp == 0);
      run_ticks(12, f);
      chk(f == ((exp == 0) ? NONE : exp), "R2/R3/R6 pulse tick", f,
          (exp == 0) ? NONE : exp);
      run_ticks(1, f);
    end

    // R4 restart
    cfg_write(32'd4);
    event_in(1'b1, 1'b1);
    run_ticks(2, f);
    chk(f == NONE, "R4 before restart", f, NONE);
    event_in(1'b1, 1'b1);
    run_ticks(8, f);
    chk(f == 4, "R4 restart", f, 4);

    // R7 flush during countdown
    cfg_write(32'd5);
    event_in(1'b1, 1'b1);
    run_ticks(1, f);
    cfg_write(32'h8000_0005);
    chk(irq == 1'b1, "R7 flush pulse", irq, 1);
    @(negedge clk);
    chk(irq == 1'b0, "R7 single cycle", irq, 0);
    run_ticks(8, f);
    chk(f == NONE, "R7 countdown cleared", f, NONE);

    // R8 flush while idle
    cfg_write(32'h8000_0003);
    chk(irq == 1'b0, "R8 idle flush", irq, 0);
    run_ticks(8, f);
    chk(f == NONE, "R8 no later pulse", f, NONE);

    // R5 immediate cancels a running countdown
    event_in(1'b1, 1'b1);
    run_ticks(1, f);
    event_in(1'b1, 1'b0);
    chk(irq == 1'b1, "R5 immediate", irq, 1);
    run_ticks(6, f);
    chk(f == NONE, "R5 cancelled", f, NONE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule